// File: doc/BRIEF.md
# Precise Trap Commit Controller

This block tracks the instructions of a five-stage in-order pipeline and decides when a trap is taken. A fault found in fetch, decode or execute is not acted on in that stage. The block records the fault and a cause code beside the instruction's PC in its own pipeline of slot tags, and moves the tag down with the instruction. The trap decision is made in one place only: the memory stage, which is the commit point. There, a recorded fault, a data address fault raised in the memory stage itself, or a pending external interrupt turns into a trap.

When a trap is taken, all four front stages are killed in the same cycle, and the memory-stage instruction is not allowed to store. The block then latches the cause code and the faulting PC (the exception PC), and on the next cycle drives a redirect to the handler base address into fetch. The handler therefore sees a precise machine state. Every older instruction has left the memory stage and retires. No younger instruction writes memory or the register file. The exception PC is kept on an output so that a return sequence can read it back.

The pipeline advances one slot every cycle. An invalid slot is a bubble, and a bubble never traps.

Top module: `trap_commit_ctrl`

## Requirements
- R1: A fault seen in fetch, decode or execute causes no kill until the faulting instruction reaches the memory stage.
- R2: When the instruction at the memory stage has a data address fault and a younger instruction has a fault in the same cycle, the older instruction's trap is taken, with cause 4 and the older PC.
- R3: When one instruction faults in several stages, the earliest stage's cause is kept. For example, a fetch fault followed by an illegal opcode and an overflow reports cause 1.
- R4: An interrupt request that arrives while a valid instruction with a pending exception sits at the memory stage overrides that exception and reports cause 0.
- R5: In the trap cycle, kill_o equals 4'b1111 and store_ok_o is low. In the next cycle, redirect_valid_o is high, redirect_pc_o holds the handler base that was sampled in the trap cycle, and kill_o[0] kills the fetch slot of that cycle. kill_o bit 0 is fetch, bit 1 decode, bit 2 execute and bit 3 memory.
- R6: Cause codes are 0 for an interrupt, 1 for a fetch address fault, 2 for an illegal opcode, 3 for an overflow and 4 for a data address fault.
- R7: epc_o holds the trapped instruction's PC. Instructions older than it retire. The trapped instruction and every younger one, including the slot fetched during the redirect cycle, never retire.
- R8: Fault inputs that are raised against bubbles have no effect: no kill, no retirement, and cause_o and epc_o stay unchanged.
- R9: An interrupt request is taken only when a valid instruction is at the memory stage. A request that is held through bubbles is taken on the first valid instruction to reach that stage.
- R10: After reset, redirect_valid_o, wb_valid_o and kill_o are zero, and cause_o and epc_o are zero.
- R11: An instruction without a fault reaches the memory stage three cycles after fetch, with store_ok_o high. It retires on the next cycle with wb_valid_o high and wb_pc_o equal to its PC, and instructions retire in program order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid_i | input | 1 | A valid instruction is in the fetch slot |
| fetch_pc_i | input | XLEN | PC of the fetch slot |
| fetch_fault_i | input | 1 | Instruction address fault on the fetch slot |
| dec_illegal_i | input | 1 | Illegal opcode on the decode-stage instruction |
| ex_overflow_i | input | 1 | Arithmetic overflow on the execute-stage instruction |
| mem_fault_i | input | 1 | Data address fault on the memory-stage instruction |
| irq_i | input | 1 | External interrupt request, level sensitive |
| handler_base_i | input | XLEN | Trap handler entry address |
| kill_o | output | 4 | Per-stage kill: bit 0 fetch, 1 decode, 2 execute, 3 memory |
| store_ok_o | output | 1 | The memory-stage instruction may write memory |
| wb_valid_o | output | 1 | An instruction retires in writeback this cycle |
| wb_pc_o | output | XLEN | PC of the retiring instruction |
| redirect_valid_o | output | 1 | Fetch must restart at redirect_pc_o |
| redirect_pc_o | output | XLEN | Handler PC for fetch |
| cause_o | output | 4 | Cause code of the last trap |
| epc_o | output | XLEN | PC of the last trapped instruction |

## Verification
The hardest case to reach is two faults on two different instructions in the same cycle, with each instruction in a different stage. The stimulus gets there by counting the three-cycle walk from fetch to the memory stage, so that a data fault on the older instruction and an overflow on the younger one arrive on the same clock. A second hard case is one instruction that collects faults in fetch, decode and execute as it moves down the pipe. A third is an interrupt that is held high through bubbles and must wait for the next valid instruction. A scoreboard takes every retirement and every redirect in order, so that any retirement the trap was meant to kill shows up as an unexpected item.

// File: rtl/tc_pkg.sv
package tc_pkg;

  typedef enum logic [3:0] {
    CAUSE_IRQ     = 4'd0,
    CAUSE_FETCH   = 4'd1,
    CAUSE_ILLEGAL = 4'd2,
    CAUSE_OVF     = 4'd3,
    CAUSE_DATA    = 4'd4
  } cause_e;

  // Per-slot tag carried down the pipe next to the PC
  typedef struct packed {
    logic   valid;
    logic   exc;
    cause_e code;
  } slot_tag_t;

  // Cause produced by the checker of each stage (0 fetch .. 3 memory)
  function automatic cause_e stage_cause(input int s);
    case (s)
      0:       return CAUSE_FETCH;
      1:       return CAUSE_ILLEGAL;
      2:       return CAUSE_OVF;
      default: return CAUSE_DATA;
    endcase
  endfunction

endpackage

// File: rtl/tc_stage.sv
module tc_stage
  import tc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  slot_tag_t        tag_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic             fault_i,
  input  cause_e           code_i,
  output slot_tag_t        tag_o,
  output logic [XLEN-1:0]  pc_o
);

  slot_tag_t       tag_q;
  logic [XLEN-1:0] pc_q;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      tag_q <= '0;
    end else begin
      tag_q <= tag_i;
    end
    if (rst) pc_q <= '0;
    else     pc_q <= pc_i;
  end

  // A fault detected here only counts if no earlier stage already flagged one
  always_comb begin
    tag_o = tag_q;
    if (tag_q.valid && !tag_q.exc && fault_i) begin
      tag_o.exc  = 1'b1;
      tag_o.code = code_i;
    end
  end

  assign pc_o = pc_q;

endmodule

// File: rtl/tc_commit.sv
module tc_commit
  import tc_pkg::*;
(
  input  slot_tag_t m_tag,
  input  logic      irq,
  output logic      take,
  output cause_e    cause
);

  always_comb begin
    take  = m_tag.valid && (irq || m_tag.exc);
    cause = irq ? CAUSE_IRQ : m_tag.code;
  end

endmodule

// File: rtl/tc_trap_regs.sv
module tc_trap_regs
  import tc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  cause_e           cause_in,
  input  logic [XLEN-1:0]  trap_pc,
  input  logic [XLEN-1:0]  handler_base,
  input  logic             retire,
  input  logic [XLEN-1:0]  retire_pc,
  output logic             wb_valid,
  output logic [XLEN-1:0]  wb_pc,
  output logic             redirect_valid,
  output logic [XLEN-1:0]  redirect_pc,
  output logic [3:0]       cause_q,
  output logic [XLEN-1:0]  epc_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_valid       <= 1'b0;
      wb_pc          <= '0;
      redirect_valid <= 1'b0;
      redirect_pc    <= '0;
      cause_q        <= '0;
      epc_q          <= '0;
    end else begin
      wb_valid       <= retire;
      redirect_valid <= take;
      if (retire) wb_pc <= retire_pc;
      if (take) begin
        redirect_pc <= handler_base;
        cause_q     <= cause_in;
        epc_q       <= trap_pc;
      end
    end
  end

endmodule

// File: rtl/trap_commit_ctrl.sv
module trap_commit_ctrl
  import tc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fetch_valid_i,
  input  logic [XLEN-1:0]  fetch_pc_i,
  input  logic             fetch_fault_i,
  input  logic             dec_illegal_i,
  input  logic             ex_overflow_i,
  input  logic             mem_fault_i,
  input  logic             irq_i,
  input  logic [XLEN-1:0]  handler_base_i,
  output logic [3:0]       kill_o,
  output logic             store_ok_o,
  output logic             wb_valid_o,
  output logic [XLEN-1:0]  wb_pc_o,
  output logic             redirect_valid_o,
  output logic [XLEN-1:0]  redirect_pc_o,
  output logic [3:0]       cause_o,
  output logic [XLEN-1:0]  epc_o
);

  localparam int NSTAGE = 4;
  localparam int MSTG   = NSTAGE - 1;

  slot_tag_t       view    [NSTAGE];
  logic [XLEN-1:0] pcv     [NSTAGE];
  logic [NSTAGE-1:0] stage_fault;
  logic [NSTAGE-1:0] kill;
  logic            take;
  cause_e          trap_cause;

  assign stage_fault = {mem_fault_i, ex_overflow_i, dec_illegal_i, 1'b0};

  // Fetch slot view
  always_comb begin
    view[0].valid = fetch_valid_i;
    view[0].exc   = fetch_valid_i && fetch_fault_i;
    view[0].code  = stage_cause(0);
  end
  assign pcv[0] = fetch_pc_i;

  for (genvar s = 1; s < NSTAGE; s++) begin : g_stage
    tc_stage #(.XLEN(XLEN)) u_stg (
      .clk     (clk),
      .rst     (rst),
      .flush   (kill[s-1]),
      .tag_i   (view[s-1]),
      .pc_i    (pcv[s-1]),
      .fault_i (stage_fault[s]),
      .code_i  (stage_cause(s)),
      .tag_o   (view[s]),
      .pc_o    (pcv[s])
    );
  end

  tc_commit u_commit (
    .m_tag (view[MSTG]),
    .irq   (irq_i),
    .take  (take),
    .cause (trap_cause)
  );

  // Memory, execute, decode die on a trap; fetch also dies during the redirect cycle
  assign kill = {{(NSTAGE-1){take}}, take | redirect_valid_o};

  tc_trap_regs #(.XLEN(XLEN)) u_regs (
    .clk            (clk),
    .rst            (rst),
    .take           (take),
    .cause_in       (trap_cause),
    .trap_pc        (pcv[MSTG]),
    .handler_base   (handler_base_i),
    .retire         (view[MSTG].valid && !take),
    .retire_pc      (pcv[MSTG]),
    .wb_valid       (wb_valid_o),
    .wb_pc          (wb_pc_o),
    .redirect_valid (redirect_valid_o),
    .redirect_pc    (redirect_pc_o),
    .cause_q        (cause_o),
    .epc_q          (epc_o)
  );

  assign kill_o     = kill;
  assign store_ok_o = view[MSTG].valid && !take;

endmodule

// File: rtl/tc_chk.sv
module tc_chk #(
  parameter int XLEN = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             irq_i,
  input logic [XLEN-1:0]  handler_base_i,
  input logic [3:0]       kill_o,
  input logic             store_ok_o,
  input logic             wb_valid_o,
  input logic             redirect_valid_o,
  input logic [XLEN-1:0]  redirect_pc_o,
  input logic [3:0]       cause_o
);

  // R5
  trap_kill_all_chk: assert property (@(posedge clk) disable iff (rst)
    kill_o[3] |-> (kill_o == 4'hF) && !store_ok_o);

  // R5
  trap_redirect_chk: assert property (@(posedge clk) disable iff (rst)
    kill_o[3] |=> redirect_valid_o && (redirect_pc_o == $past(handler_base_i)));

  // R5
  redirect_fetch_kill_chk: assert property (@(posedge clk) disable iff (rst)
    redirect_valid_o |-> kill_o[0]);

  // R7
  no_retire_after_trap_chk: assert property (@(posedge clk) disable iff (rst)
    kill_o[3] |=> !wb_valid_o);

  // R4
  irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (kill_o[3] && irq_i) |=> (cause_o == 4'd0));

  // R11
  store_then_retire_chk: assert property (@(posedge clk) disable iff (rst)
    store_ok_o |=> wb_valid_o);

  // R10
  reset_state_chk: assert property (@(posedge clk)
    rst |=> !redirect_valid_o && !wb_valid_o && (cause_o == 4'd0));

endmodule

bind trap_commit_ctrl tc_chk #(.XLEN(XLEN)) u_chk (
  .clk              (clk),
  .rst              (rst),
  .irq_i            (irq_i),
  .handler_base_i   (handler_base_i),
  .kill_o           (kill_o),
  .store_ok_o       (store_ok_o),
  .wb_valid_o       (wb_valid_o),
  .redirect_valid_o (redirect_valid_o),
  .redirect_pc_o    (redirect_pc_o),
  .cause_o          (cause_o)
);

// File: tb/sim_trap_commit_ctrl.sv
module sim_trap_commit_ctrl;

  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            fetch_valid_i = 1'b0;
  logic [XLEN-1:0] fetch_pc_i = '0;
  logic            fetch_fault_i = 1'b0;
  logic            dec_illegal_i = 1'b0;
  logic            ex_overflow_i = 1'b0;
  logic            mem_fault_i = 1'b0;
  logic            irq_i = 1'b0;
  logic [XLEN-1:0] handler_base_i = '0;
  logic [3:0]      kill_o;
  logic            store_ok_o;
  logic            wb_valid_o;
  logic [XLEN-1:0] wb_pc_o;
  logic            redirect_valid_o;
  logic [XLEN-1:0] redirect_pc_o;
  logic [3:0]      cause_o;
  logic [XLEN-1:0] epc_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    bit              trap;
    logic [XLEN-1:0] pc;
    logic [3:0]      cause;
    logic [XLEN-1:0] hpc;
    string           req;
  } exp_t;
  exp_t expq[$];

  always #5 clk = ~clk;

  trap_commit_ctrl #(.XLEN(XLEN)) u0 (.*);

  task automatic check(input string req, input string what,
                       input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  // Driver: one pipeline cycle of stimulus, applied at the falling edge
  task automatic drv(input logic fv, input logic [XLEN-1:0] fpc,
                     input logic ff, input logic di, input logic eo,
                     input logic mf, input logic iq);
    @(negedge clk);
    fetch_valid_i = fv;
    fetch_pc_i    = fpc;
    fetch_fault_i = ff;
    dec_illegal_i = di;
    ex_overflow_i = eo;
    mem_fault_i   = mf;
    irq_i         = iq;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drv(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic comb(input string req, input logic [3:0] k, input logic so);
    #1;
    check(req, "kill_o", {28'd0, kill_o}, {28'd0, k});
    check(req, "store_ok_o", {31'd0, store_ok_o}, {31'd0, so});
  endtask

  task automatic push_ret(input logic [XLEN-1:0] pc, input string req);
    exp_t e;
    e.trap = 1'b0; e.pc = pc; e.cause = '0; e.hpc = '0; e.req = req;
    expq.push_back(e);
  endtask

  task automatic push_trap(input logic [3:0] c, input logic [XLEN-1:0] pc,
                           input string req);
    exp_t e;
    e.trap = 1'b1; e.pc = pc; e.cause = c; e.hpc = handler_base_i; e.req = req;
    expq.push_back(e);
  endtask

  task automatic drained(input string req);
    check(req, "pending scoreboard items", expq.size(), 0);
  endtask

  // Monitor: pops expected items as retirements and redirects appear
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (!rst && wb_valid_o) begin
        if (expq.size() == 0 || expq[0].trap) begin
          checks++; errors++;
          $display("FAIL R7 unexpected retirement: got pc %h expected none", wb_pc_o);
        end else begin
          check(expq[0].req, "wb_pc_o", wb_pc_o, expq[0].pc);
          void'(expq.pop_front());
        end
      end
      if (!rst && redirect_valid_o) begin
        if (expq.size() == 0 || !expq[0].trap) begin
          checks++; errors++;
          $display("FAIL R5 unexpected redirect: got epc %h expected none", epc_o);
        end else begin
          check(expq[0].req, "cause_o", {28'd0, cause_o}, {28'd0, expq[0].cause});
          check(expq[0].req, "epc_o", epc_o, expq[0].pc);
          check(expq[0].req, "redirect_pc_o", redirect_pc_o, expq[0].hpc);
          void'(expq.pop_front());
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (3000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got no completion expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R10 reset state
    check("R10", "redirect_valid_o", {31'd0, redirect_valid_o}, 0);
    check("R10", "wb_valid_o", {31'd0, wb_valid_o}, 0);
    check("R10", "kill_o", {28'd0, kill_o}, 0);
    check("R10", "cause_o", {28'd0, cause_o}, 0);
    check("R10", "epc_o", epc_o, 0);

    // R11 plain flow, in-order retirement
    handler_base_i = 32'h0000_8000;
    push_ret(32'h100, "R11"); push_ret(32'h104, "R11");
    push_ret(32'h108, "R11"); push_ret(32'h10C, "R11");
    drv(1, 32'h100, 0, 0, 0, 0, 0);
    drv(1, 32'h104, 0, 0, 0, 0, 0);
    drv(1, 32'h108, 0, 0, 0, 0, 0);
    drv(1, 32'h10C, 0, 0, 0, 0, 0);
    comb("R11", 4'b0000, 1'b1);
    idle(6);
    drained("R11");

    // R5 R6 R7 overflow on B, A older retires, C and redirect slot die
    handler_base_i = 32'h8000_0000;
    push_ret(32'h200, "R7");
    push_trap(4'd3, 32'h204, "R6");
    drv(1, 32'h200, 0, 0, 0, 0, 0);
    drv(1, 32'h204, 0, 0, 0, 0, 0);
    drv(1, 32'h208, 0, 0, 0, 0, 0);
    drv(0, 32'h0, 0, 0, 1, 0, 0);
    drv(0, 32'h0, 0, 0, 0, 0, 0);
    comb("R5", 4'b1111, 1'b0);
    drv(1, 32'hBAD0, 0, 0, 0, 0, 0);
    comb("R5", 4'b0001, 1'b0);
    idle(6);
    drained("R7");

    // R8 faults on bubbles only
    for (int i = 0; i < 6; i++) begin
      drv(0, 32'hDEAD, 1, 1, 1, 1, 0);
      comb("R8", 4'b0000, 1'b0);
    end
    idle(4);
    check("R8", "cause_o", {28'd0, cause_o}, 32'd3);
    check("R8", "epc_o", epc_o, 32'h204);
    drained("R8");

    // R2 older data fault vs younger overflow in the same cycle
    handler_base_i = 32'h8000_0100;
    push_trap(4'd4, 32'h300, "R2");
    drv(1, 32'h300, 0, 0, 0, 0, 0);
    drv(1, 32'h304, 0, 0, 0, 0, 0);
    drv(0, 32'h0, 0, 0, 0, 0, 0);
    drv(0, 32'h0, 0, 0, 1, 1, 0);
    comb("R2", 4'b1111, 1'b0);
    idle(6);
    drained("R2");

    // R3 R1 same instruction faults in fetch, decode, execute
    handler_base_i = 32'h8000_0200;
    push_trap(4'd1, 32'h400, "R3");
    drv(1, 32'h400, 1, 0, 0, 0, 0);
    comb("R1", 4'b0000, 1'b0);
    drv(0, 32'h0, 0, 1, 0, 0, 0);
    comb("R1", 4'b0000, 1'b0);
    drv(0, 32'h0, 0, 0, 1, 0, 0);
    comb("R1", 4'b0000, 1'b0);
    drv(0, 32'h0, 0, 0, 0, 1, 0);
    comb("R3", 4'b1111, 1'b0);
    idle(6);
    drained("R3");

    // R4 interrupt overrides a pending illegal opcode
    handler_base_i = 32'h8000_0300;
    push_trap(4'd0, 32'h500, "R4");
    drv(1, 32'h500, 0, 0, 0, 0, 0);
    drv(0, 32'h0, 0, 1, 0, 0, 0);
    drv(0, 32'h0, 0, 0, 0, 0, 0);
    drv(0, 32'h0, 0, 0, 0, 0, 1);
    comb("R4", 4'b1111, 1'b0);
    idle(6);
    drained("R4");

    // R9 interrupt held over bubbles, taken on first valid at commit
    handler_base_i = 32'h8000_0400;
    push_trap(4'd0, 32'h600, "R9");
    for (int i = 0; i < 4; i++) begin
      drv(0, 32'h0, 0, 0, 0, 0, 1);
      comb("R9", 4'b0000, 1'b0);
    end
    drv(1, 32'h600, 0, 0, 0, 0, 1);
    drv(0, 32'h0, 0, 0, 0, 0, 1);
    drv(0, 32'h0, 0, 0, 0, 0, 1);
    drv(0, 32'h0, 0, 0, 0, 0, 1);
    comb("R9", 4'b1111, 1'b0);
    idle(6);
    drained("R9");

    // R6 illegal opcode alone gives cause 2
    handler_base_i = 32'h8000_0500;
    push_trap(4'd2, 32'h700, "R6");
    drv(1, 32'h700, 0, 0, 0, 0, 0);
    drv(0, 32'h0, 0, 1, 0, 0, 0);
    idle(8);
    drained("R6");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule